// File: doc/BRIEF.md
# Hot-Swap Power Sequencing Controller

This block is the digital sequencer that decides when a plug-in card may close its 3.3 V and 5 V power switches. It watches two active-low seating contacts, a host power-enable line and a supply-select strap. It also takes comparator results that other circuits have already turned into logic flags: undervoltage on the host supplies, undervoltage on the card-side rails, and over-current on each rail. From these it drives the enables of the two gate-driver stages, an active-low driver-status line, a latched active-low fault line, an active-low card-health line, a reset request for the card's reset generator, and a power-good indication.

Every asynchronous input first passes through a two-stage synchronizer. A four-state machine (off, ramping, on, faulted) then decides. When the card is fully seated, power is enabled and the supervised host supply is healthy, both gate enables turn on together. The machine holds in a ramp phase for a parameterised number of cycles before it reports power good. An over-current on either rail cuts both gates and latches a fault. Only a low-then-high cycle on the power enable clears that fault, and the fault line is released on the same cycle the gates come back on.

Top module: `hotswap_seq_ctrl`

## Requirements
- R1: Gate enables turn on only when both seating inputs are low (0 = seated), power enable is high, the supervised host supply shows no undervoltage and no fault is pending. They turn on on the third rising clock edge after such inputs are applied.
- R2: Both gate enables always carry the same value, and drv_on_n is 0 exactly while they are 1.
- R3: Power enable low turns both gate enables off within three clock edges and sets rst_req to 1.
- R4: An over-current flag on either rail while the gates are enabled turns both gates off and drives fault_n to 0.
- R5: A latched fault persists after the over-current flag clears and after board removal. It clears only after power enable goes low and then high again, and fault_n returns to 1 on the same clock edge as the gate enables return to 1.
- R6: With the strap vsel_3v3 = 1 the host 3.3 V undervoltage flag is supervised and the main 5 V flag is ignored. With vsel_3v3 = 0 the reverse holds. A supervised undervoltage turns the gates off and sets rst_req to 1.
- R7: healthy_n is 0 only while both card-side undervoltage flags are 0. It follows its inputs two clock edges after they change.
- R8: After the gates turn on, pwr_good stays 0 for RAMP_CYCLES clock edges and becomes 1 on the next one.
- R9: Either seating input going high returns the machine to off (gates 0, pwr_good 0) without clearing a latched fault.
- R10: During reset, gates are 0, drv_on_n = 1, fault_n = 1, healthy_n = 1, rst_req = 1 and pwr_good = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seat_a_n | input | 1 | First seating contact, 0 = seated |
| seat_b_n | input | 1 | Second seating contact, 0 = seated |
| pwr_en | input | 1 | Host power enable, 1 = power allowed |
| vsel_3v3 | input | 1 | Strap: 1 supervises host 3.3 V, 0 supervises main 5 V |
| host3_uv | input | 1 | Host 3.3 V undervoltage flag |
| main5_uv | input | 1 | Main 5 V supply undervoltage flag |
| card3_uv | input | 1 | Card-side 3.3 V undervoltage flag |
| card5_uv | input | 1 | Card-side 5 V undervoltage flag |
| oc_3v3 | input | 1 | Over-current flag on the 3.3 V rail |
| oc_5v | input | 1 | Over-current flag on the 5 V rail |
| gate3_en | output | 1 | Enable for the 3.3 V gate driver |
| gate5_en | output | 1 | Enable for the 5 V gate driver |
| drv_on_n | output | 1 | Driver status, 0 while gates are enabled |
| fault_n | output | 1 | Latched over-current fault, 0 = fault |
| healthy_n | output | 1 | Card rail health, 0 = both rails good |
| rst_req | output | 1 | Reset request to the card reset generator |
| pwr_good | output | 1 | Ramp complete, power on |

## Verification
If the state register is wrong, the gate enables, drv_on_n and pwr_good show it at the next sampling point, three edges after the stimulus. If the fault latch or its clear-arming flag is wrong, fault_n shows it directly. A fault that clears too early also shows as gates coming back on before the power-enable cycle, and a fault that never clears shows as gates that stay off after that cycle. A ramp counter off by one moves the rise of pwr_good by one cycle, and the exact-cycle checks catch that.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RAMP  = 2'd1,
    ST_ON    = 2'd2,
    ST_FAULT = 2'd3
  } hsc_state_e;

  // Bit positions of the synchronised input bundle.
  localparam int unsigned IN_SEAT_A = 0;
  localparam int unsigned IN_SEAT_B = 1;
  localparam int unsigned IN_PWREN  = 2;
  localparam int unsigned IN_VSEL   = 3;
  localparam int unsigned IN_H3UV   = 4;
  localparam int unsigned IN_M5UV   = 5;
  localparam int unsigned IN_C3UV   = 6;
  localparam int unsigned IN_C5UV   = 7;
  localparam int unsigned IN_OC3    = 8;
  localparam int unsigned IN_OC5    = 9;
  localparam int unsigned IN_W      = 10;

  // Reset image: unseated, power disabled, all supplies reported low.
  localparam logic [IN_W-1:0] IN_RST_VAL = 10'b00_1111_0_0_11;

  // Which host undervoltage flag is watched, chosen by the strap.
  function automatic logic pick_host_uv(input logic vsel_3v3,
                                        input logic h3_uv,
                                        input logic m5_uv);
    return vsel_3v3 ? h3_uv : m5_uv;
  endfunction

  function automatic logic gates_live(input hsc_state_e st);
    return (st == ST_RAMP) || (st == ST_ON);
  endfunction

endpackage

// File: rtl/hsc_sync.sv
module hsc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain[s] <= RST_VAL;
        end else if (s == 0) begin
          chain[s] <= d_async;
        end else begin
          chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hsc_monitor.sv
module hsc_monitor
  import hsc_pkg::*;
(
  input  logic [IN_W-1:0] in_s,
  output logic            seated,
  output logic            pwr_en_s,
  output logic            host_uv_sel,
  output logic            oc_any,
  output logic            healthy_n,
  output logic            rst_req
);
  assign seated      = ~in_s[IN_SEAT_A] & ~in_s[IN_SEAT_B];
  assign pwr_en_s    = in_s[IN_PWREN];
  assign host_uv_sel = pick_host_uv(in_s[IN_VSEL], in_s[IN_H3UV], in_s[IN_M5UV]);
  assign oc_any      = in_s[IN_OC3] | in_s[IN_OC5];
  assign healthy_n   = in_s[IN_C3UV] | in_s[IN_C5UV];
  assign rst_req     = ~pwr_en_s | host_uv_sel;
endmodule

// File: rtl/hsc_seq_fsm.sv
module hsc_seq_fsm
  import hsc_pkg::*;
#(
  parameter int unsigned RAMP_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seated,
  input  logic       pwr_en_s,
  input  logic       host_uv_sel,
  input  logic       oc_any,
  output hsc_state_e state,
  output logic       fault_q,
  output logic       clr_armed,
  output logic       start_ev,
  output logic       trip_ev
);
  localparam int unsigned CW = $clog2(RAMP_CYCLES + 1) + 1;

  logic [CW-1:0] ramp_cnt;
  hsc_state_e    state_d;
  logic          host_ok;
  logic          may_start;
  logic          drop_ev;

  function automatic logic ramp_last(input logic [CW-1:0] c);
    return c == CW'(RAMP_CYCLES - 1);
  endfunction

  assign host_ok   = ~host_uv_sel;
  assign may_start = seated & pwr_en_s & host_ok & ~oc_any & (~fault_q | clr_armed);
  assign trip_ev   = gates_live(state) & oc_any;
  assign drop_ev   = gates_live(state) & ~oc_any & (~seated | ~pwr_en_s | ~host_ok);
  assign start_ev  = ~gates_live(state) & may_start &
                     ~((state == ST_FAULT) & ~seated);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_OFF:   if (start_ev) state_d = ST_RAMP;
      ST_FAULT: begin
        if (!seated)       state_d = ST_OFF;
        else if (start_ev) state_d = ST_RAMP;
      end
      ST_RAMP: begin
        if (trip_ev)                 state_d = ST_FAULT;
        else if (drop_ev)            state_d = ST_OFF;
        else if (ramp_last(ramp_cnt)) state_d = ST_ON;
      end
      ST_ON: begin
        if (trip_ev)      state_d = ST_FAULT;
        else if (drop_ev) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OFF;
      ramp_cnt  <= '0;
      fault_q   <= 1'b0;
      clr_armed <= 1'b0;
    end else begin
      state <= state_d;

      if (state == ST_RAMP && state_d == ST_RAMP) ramp_cnt <= ramp_cnt + 1'b1;
      else                                         ramp_cnt <= '0;

      if (trip_ev) begin
        fault_q   <= 1'b1;
        clr_armed <= 1'b0;
      end else if (start_ev) begin
        fault_q   <= 1'b0;
        clr_armed <= 1'b0;
      end else if (fault_q && !pwr_en_s) begin
        clr_armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hotswap_seq_ctrl.sv
module hotswap_seq_ctrl
  import hsc_pkg::*;
#(
  parameter int unsigned RAMP_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seat_a_n,
  input  logic seat_b_n,
  input  logic pwr_en,
  input  logic vsel_3v3,
  input  logic host3_uv,
  input  logic main5_uv,
  input  logic card3_uv,
  input  logic card5_uv,
  input  logic oc_3v3,
  input  logic oc_5v,
  output logic gate3_en,
  output logic gate5_en,
  output logic drv_on_n,
  output logic fault_n,
  output logic healthy_n,
  output logic rst_req,
  output logic pwr_good
);
  logic [IN_W-1:0] in_raw;
  logic [IN_W-1:0] in_s;
  logic            seated;
  logic            pwr_en_s;
  logic            host_uv_sel;
  logic            oc_any;
  hsc_state_e      state;
  logic            fault_q;
  logic            clr_armed;
  logic            start_ev;
  logic            trip_ev;
  logic            gates_on;

  always_comb begin
    in_raw            = '0;
    in_raw[IN_SEAT_A] = seat_a_n;
    in_raw[IN_SEAT_B] = seat_b_n;
    in_raw[IN_PWREN]  = pwr_en;
    in_raw[IN_VSEL]   = vsel_3v3;
    in_raw[IN_H3UV]   = host3_uv;
    in_raw[IN_M5UV]   = main5_uv;
    in_raw[IN_C3UV]   = card3_uv;
    in_raw[IN_C5UV]   = card5_uv;
    in_raw[IN_OC3]    = oc_3v3;
    in_raw[IN_OC5]    = oc_5v;
  end

  hsc_sync #(
    .W       (IN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IN_RST_VAL)
  ) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (in_raw),
    .q_sync  (in_s)
  );

  hsc_monitor mon_i (
    .in_s        (in_s),
    .seated      (seated),
    .pwr_en_s    (pwr_en_s),
    .host_uv_sel (host_uv_sel),
    .oc_any      (oc_any),
    .healthy_n   (healthy_n),
    .rst_req     (rst_req)
  );

  hsc_seq_fsm #(
    .RAMP_CYCLES (RAMP_CYCLES)
  ) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .seated      (seated),
    .pwr_en_s    (pwr_en_s),
    .host_uv_sel (host_uv_sel),
    .oc_any      (oc_any),
    .state       (state),
    .fault_q     (fault_q),
    .clr_armed   (clr_armed),
    .start_ev    (start_ev),
    .trip_ev     (trip_ev)
  );

  assign gates_on = gates_live(state);
  assign gate3_en = gates_on;
  assign gate5_en = gates_on;
  assign drv_on_n = ~gates_on;
  assign fault_n  = ~fault_q;
  assign pwr_good = (state == ST_ON);
endmodule

// File: rtl/hsc_checker.sv
module hsc_checker #(
  parameter int unsigned RAMP_CYCLES = 16
) (
  input logic clk,
  input logic rst_n,
  input logic seated,
  input logic pwr_en_s,
  input logic host_uv_sel,
  input logic oc_any,
  input logic gate3_en,
  input logic gate5_en,
  input logic fault_n,
  input logic rst_req,
  input logic pwr_good
);
  localparam int unsigned KW = $clog2(RAMP_CYCLES + 2) + 1;
  logic [KW-1:0] on_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         on_cnt <= '0;
    else if (!gate3_en)                 on_cnt <= '0;
    else if (on_cnt != KW'(RAMP_CYCLES + 1)) on_cnt <= on_cnt + 1'b1;
  end

  // R1: a live gate needs seating, power enable and a good host supply one cycle earlier
  p_gate_needs_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gate3_en |-> $past(seated && pwr_en_s && !host_uv_sel));

  // R2: both rails switch together
  p_rails_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate3_en == gate5_en);

  // R3: power enable low means a reset request
  p_pwren_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en_s |-> rst_req);

  // R4: over-current with gates live trips next cycle
  p_oc_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate3_en && oc_any) |=> (!fault_n && !gate3_en));

  // R5: the fault line is only released together with the gates coming back
  p_fault_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> $rose(gate3_en));

  // R6: a supervised host undervoltage drops the gates
  p_host_uv_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_uv_sel |=> !gate3_en);

  // R8: power good rises exactly after the ramp window
  p_ramp_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> (on_cnt == KW'(RAMP_CYCLES)));

  // R9: removal keeps a latched fault
  p_remove_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!seated && !fault_n) |=> !fault_n);
endmodule

bind hotswap_seq_ctrl hsc_checker #(
  .RAMP_CYCLES (RAMP_CYCLES)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .seated      (seated),
  .pwr_en_s    (pwr_en_s),
  .host_uv_sel (host_uv_sel),
  .oc_any      (oc_any),
  .gate3_en    (gate3_en),
  .gate5_en    (gate5_en),
  .fault_n     (fault_n),
  .rst_req     (rst_req),
  .pwr_good    (pwr_good)
);

// File: tb/hotswap_seq_ctrl_tb_top.sv
module hotswap_seq_ctrl_tb_top;
  localparam int unsigned RC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seat_a_n = 1'b1, seat_b_n = 1'b1, pwr_en = 1'b0, vsel_3v3 = 1'b1;
  logic host3_uv = 1'b0, main5_uv = 1'b0, card3_uv = 1'b0, card5_uv = 1'b0;
  logic oc_3v3 = 1'b0, oc_5v = 1'b0;
  logic gate3_en, gate5_en, drv_on_n, fault_n, healthy_n, rst_req, pwr_good;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  hotswap_seq_ctrl #(.RAMP_CYCLES(RC), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .seat_a_n(seat_a_n), .seat_b_n(seat_b_n),
    .pwr_en(pwr_en), .vsel_3v3(vsel_3v3), .host3_uv(host3_uv),
    .main5_uv(main5_uv), .card3_uv(card3_uv), .card5_uv(card5_uv),
    .oc_3v3(oc_3v3), .oc_5v(oc_5v), .gate3_en(gate3_en), .gate5_en(gate5_en),
    .drv_on_n(drv_on_n), .fault_n(fault_n), .healthy_n(healthy_n),
    .rst_req(rst_req), .pwr_good(pwr_good));

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // gates, both rails and driver status against one expected value
  task automatic chk_gates(input string req, input logic exp);
    chk(req, "gate3_en", gate3_en, exp);
    chk(req, "gate5_en", gate5_en, exp);
    chk("R2", "drv_on_n", drv_on_n, ~exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    step(2);
    chk_gates("R10", 1'b0);
    chk("R10", "fault_n", fault_n, 1'b1);
    chk("R10", "healthy_n", healthy_n, 1'b1);
    chk("R10", "rst_req", rst_req, 1'b1);
    chk("R10", "pwr_good", pwr_good, 1'b0);
    rst_n = 1'b1;
    seat_a_n = 1'b0; seat_b_n = 1'b0;
    step(4);
    chk_gates("R1", 1'b0);  // power enable still low
  endtask

  task automatic t_start();
    pwr_en = 1'b1;
    step(2);
    chk_gates("R1", 1'b0);
    step(1);
    chk_gates("R1", 1'b1);
    chk("R8", "pwr_good in ramp", pwr_good, 1'b0);
    chk("R3", "rst_req released", rst_req, 1'b0);
    step(RC - 1);
    chk("R8", "pwr_good last ramp cycle", pwr_good, 1'b0);
    step(1);
    chk("R8", "pwr_good after ramp", pwr_good, 1'b1);
  endtask

  task automatic t_pwr_cycle();
    pwr_en = 1'b0;
    step(3);
    chk_gates("R3", 1'b0);
    chk("R3", "rst_req", rst_req, 1'b1);
    chk("R3", "pwr_good", pwr_good, 1'b0);
    pwr_en = 1'b1;
    step(3 + RC);
    chk("R3", "pwr_good restart", pwr_good, 1'b1);
  endtask

  task automatic t_oc5_and_removal();
    oc_5v = 1'b1;
    step(3);
    chk_gates("R4", 1'b0);
    chk("R4", "fault_n", fault_n, 1'b0);
    oc_5v = 1'b0;
    step(5);
    chk_gates("R5", 1'b0);
    chk("R5", "fault_n held", fault_n, 1'b0);
    seat_a_n = 1'b1;
    step(4);
    chk("R9", "fault_n after removal", fault_n, 1'b0);
    chk("R9", "pwr_good", pwr_good, 1'b0);
    seat_a_n = 1'b0;
    step(4);
    chk_gates("R5", 1'b0);  // reseat alone does not clear
    pwr_en = 1'b0;
    step(4);
    chk("R5", "fault_n while enable low", fault_n, 1'b0);
    pwr_en = 1'b1;
    step(2);
    chk("R5", "fault_n before restart", fault_n, 1'b0);
    chk_gates("R5", 1'b0);
    step(1);
    chk("R5", "fault_n released", fault_n, 1'b1);
    chk_gates("R5", 1'b1);
    step(RC);
    chk("R8", "pwr_good after clear", pwr_good, 1'b1);
  endtask

  task automatic t_oc3();
    oc_3v3 = 1'b1;
    step(1);
    oc_3v3 = 1'b0;
    step(2);
    chk_gates("R4", 1'b0);
    chk("R4", "fault_n 3v3 trip", fault_n, 1'b0);
    pwr_en = 1'b0;
    step(3);
    pwr_en = 1'b1;
    step(3 + RC);
    chk("R5", "fault_n after cycle", fault_n, 1'b1);
    chk("R5", "pwr_good after cycle", pwr_good, 1'b1);
  endtask

  task automatic t_vsel();
    vsel_3v3 = 1'b1;
    main5_uv = 1'b1;
    step(4);
    chk_gates("R6", 1'b1);  // unsupervised flag ignored
    chk("R6", "rst_req ignores 5V", rst_req, 1'b0);
    host3_uv = 1'b1;
    step(3);
    chk_gates("R6", 1'b0);
    chk("R6", "rst_req 3V3 uv", rst_req, 1'b1);
    host3_uv = 1'b0;
    step(3 + RC);
    chk("R6", "pwr_good back", pwr_good, 1'b1);
    chk("R6", "no fault from uv", fault_n, 1'b1);
    vsel_3v3 = 1'b0;    // 5V flag still high, now supervised
    step(3);
    chk_gates("R6", 1'b0);
    chk("R6", "rst_req 5V uv", rst_req, 1'b1);
    main5_uv = 1'b0;
    host3_uv = 1'b1;    // now ignored
    step(3 + RC);
    chk("R6", "pwr_good 3V3 ignored", pwr_good, 1'b1);
    host3_uv = 1'b0;
    vsel_3v3 = 1'b1;
  endtask

  task automatic t_health();
    step(1);
    chk("R7", "healthy_n both good", healthy_n, 1'b0);
    card3_uv = 1'b1;
    step(1);
    chk("R7", "healthy_n one edge", healthy_n, 1'b0);
    step(1);
    chk("R7", "healthy_n 3V3 low", healthy_n, 1'b1);
    card3_uv = 1'b0; card5_uv = 1'b1;
    step(2);
    chk("R7", "healthy_n 5V low", healthy_n, 1'b1);
    card5_uv = 1'b0;
    step(2);
    chk("R7", "healthy_n recovered", healthy_n, 1'b0);
  endtask

  task automatic t_remove_b();
    seat_b_n = 1'b1;
    step(3);
    chk_gates("R9", 1'b0);
    chk("R9", "pwr_good off", pwr_good, 1'b0);
    chk("R9", "no fault", fault_n, 1'b1);
    seat_b_n = 1'b0;
    step(3);
    chk_gates("R1", 1'b1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_start();
    t_pwr_cycle();
    t_oc5_and_removal();
    t_oc3();
    t_vsel();
    t_health();
    t_remove_b();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule